// File: doc/BRIEF.md
# DRAM Chip-Select Address Mapper

This block turns a flat bus address into DRAM coordinates for a controller that drives up to two memory chips. The top byte of the address picks the chip. Each chip has an 8-bit base and an 8-bit mask, and it claims the address when the masked top byte equals its masked base. The second chip takes part only when software marks it as fitted. An address that no chip claims raises a decode error instead of a chip select.

The remaining 24 offset bits become bank, row and column numbers. First the byte-lane bits are dropped, which is 2 bits for a 32-bit data path and 1 bit for a 16-bit one. The column field takes the lowest bits. The row and bank fields then sit above the column in one of two orders. Linear order places the bank at the top. Interleaved order places the bank directly above the column, so that consecutive column pages fall in different banks. Field widths come from runtime configuration: 12 to 15 row bits, 7 to 11 column bits, and 4 or 8 banks.

The result is registered once. It appears one clock after the request, together with a valid flag.

Top module: `dam_addr_map`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output is zero after that edge.
- R2: `map_valid` equals `req_valid` from one clock earlier. When `map_valid` is low, `cs_sel`, `bank`, `row`, `col` and `dec_err` are all zero.
- R3: Chip k matches when `(req_addr[31:24] & mask_k) == (base_k & mask_k)`. A selected chip k is reported as the one-hot bit k of `cs_sel`: bit 0 is chip 0 and bit 1 is chip 1.
- R4: Chip 1 can match only while `cs1_present` is 1.
- R5: When both chips match, chip 0 is selected.
- R6: When no chip matches, `dec_err` is 1, and `cs_sel`, `bank`, `row` and `col` are 0.
- R7: The offset is `req_addr[23:0]`. It is shifted right by 2 when `wide32`=1 and by 1 when `wide32`=0, which gives the word index W.
- R8: The column is the low 7+`col_sel` bits of W. Values of `col_sel` above 4 act as 4, which gives 11 bits. Unused upper bits of `col` are 0.
- R9: The row field is 12+`row_sel` bits wide. The bank field is 3 bits wide when `bank8`=1 and 2 bits wide when `bank8`=0. Unused upper bits of `row` and `bank` are 0.
- R10: With `interleave`=0, the fields from most significant to least significant are bank, row, column.
- R11: With `interleave`=1, the fields from most significant to least significant are row, bank, column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Address on `req_addr` is to be mapped |
| req_addr | input | 32 | Bus byte address |
| cs0_base | input | 8 | Chip 0 base value for the top address byte |
| cs0_mask | input | 8 | Chip 0 compare mask, 1 = bit compared |
| cs1_base | input | 8 | Chip 1 base value for the top address byte |
| cs1_mask | input | 8 | Chip 1 compare mask, 1 = bit compared |
| cs1_present | input | 1 | Chip 1 is fitted and takes part in decoding |
| row_sel | input | 2 | Row bits minus 12 |
| col_sel | input | 3 | Column bits minus 7, clamped at 4 |
| bank8 | input | 1 | 1 = 8 banks, 0 = 4 banks |
| wide32 | input | 1 | 1 = 32-bit data path, 0 = 16-bit |
| interleave | input | 1 | 1 = bank field directly above column |
| map_valid | output | 1 | Registered result is valid |
| cs_sel | output | 2 | One-hot chip select |
| bank | output | 3 | Bank number |
| row | output | 15 | Row number |
| col | output | 11 | Column number |
| dec_err | output | 1 | Address matched no chip |

## Verification
The assertions check several properties on every cycle:
- the one-cycle valid pipeline and the quiet outputs when idle;
- that `cs_sel` is never more than one-hot;
- that a decode error and a chip select never appear together;
- that chip 1 stays unselected when it is not fitted;
- that field bits above the configured column, row and bank widths remain zero.

Some behaviour only the bench's scenarios can show. These are the actual bit positions of bank, row and column in both orders, the byte-lane drop for each data width, the column clamp, and the priority of chip 0 when the two chips overlap. Each of these needs a known address paired with a hand-computed result.

// File: rtl/dam_pkg.sv
package dam_pkg;

    localparam int NUM_CS   = 2;
    localparam int ROW_MIN  = 12;
    localparam int ROW_MAX  = 15;
    localparam int COL_MIN  = 7;
    localparam int COL_MAX  = 11;
    localparam int BANK_MAX = 3;
    localparam int COL_SEL_CAP = COL_MAX - COL_MIN;

    typedef enum logic {
        MAP_LINEAR      = 1'b0,
        MAP_INTERLEAVED = 1'b1
    } map_mode_t;

    typedef struct packed {
        logic [1:0] row_sel;
        logic [2:0] col_sel;
        logic       bank8;
        logic       wide32;
        map_mode_t  mode;
    } map_cfg_t;

    typedef struct packed {
        logic [BANK_MAX-1:0] bank;
        logic [ROW_MAX-1:0]  row;
        logic [COL_MAX-1:0]  col;
    } dram_coord_t;

    typedef struct packed {
        logic              valid;
        logic [NUM_CS-1:0] cs;
        dram_coord_t       coord;
        logic              err;
    } map_out_t;

    function automatic logic [31:0] low_mask(input logic [4:0] nbits);
        low_mask = (32'd1 << nbits) - 32'd1;
    endfunction

endpackage

// File: rtl/dam_cs_match.sv
module dam_cs_match #(
    parameter int SEL_W = 8
) (
    input  logic [SEL_W-1:0] top_bits,
    input  logic [SEL_W-1:0] base,
    input  logic [SEL_W-1:0] mask,
    input  logic             enable,
    output logic             hit
);
    always_comb begin
        hit = enable && ((top_bits & mask) == (base & mask));
    end
endmodule

// File: rtl/dam_cs_pick.sv
module dam_cs_pick #(
    parameter int N = 2
) (
    input  logic [N-1:0] hits,
    output logic [N-1:0] sel,
    output logic         miss
);
    always_comb begin
        sel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                sel = '0;
                sel[i] = 1'b1;
            end
        end
        miss = (hits == '0);
    end
endmodule

// File: rtl/dam_field_split.sv
module dam_field_split
    import dam_pkg::*;
#(
    parameter int OFF_W = 24
) (
    input  logic [OFF_W-1:0] offset,
    input  map_cfg_t         cfg,
    output dram_coord_t      coord
);
    logic [2:0]       col_ext;
    logic [4:0]       n_col;
    logic [4:0]       n_row;
    logic [4:0]       n_bank;
    logic [OFF_W-1:0] words;
    logic [OFF_W-1:0] above_col;
    logic [OFF_W-1:0] row_src;
    logic [OFF_W-1:0] bank_src;

    always_comb begin
        col_ext = (cfg.col_sel > 3'(COL_SEL_CAP)) ? 3'(COL_SEL_CAP) : cfg.col_sel;
        n_col   = 5'(COL_MIN) + 5'(col_ext);
        n_row   = 5'(ROW_MIN) + 5'(cfg.row_sel);
        n_bank  = cfg.bank8 ? 5'd3 : 5'd2;

        words     = cfg.wide32 ? (offset >> 2) : (offset >> 1);
        above_col = words >> n_col;

        if (cfg.mode == MAP_LINEAR) begin
            row_src  = above_col;
            bank_src = above_col >> n_row;
        end else begin
            bank_src = above_col;
            row_src  = above_col >> n_bank;
        end

        coord.col  = words[COL_MAX-1:0]     & COL_MAX'(low_mask(n_col));
        coord.row  = row_src[ROW_MAX-1:0]   & ROW_MAX'(low_mask(n_row));
        coord.bank = bank_src[BANK_MAX-1:0] & BANK_MAX'(low_mask(n_bank));
    end
endmodule

// File: rtl/dam_addr_map.sv
module dam_addr_map
    import dam_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SEL_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [SEL_W-1:0]     cs0_base,
    input  logic [SEL_W-1:0]     cs0_mask,
    input  logic [SEL_W-1:0]     cs1_base,
    input  logic [SEL_W-1:0]     cs1_mask,
    input  logic                 cs1_present,
    input  logic [1:0]           row_sel,
    input  logic [2:0]           col_sel,
    input  logic                 bank8,
    input  logic                 wide32,
    input  logic                 interleave,
    output logic                 map_valid,
    output logic [NUM_CS-1:0]    cs_sel,
    output logic [BANK_MAX-1:0]  bank,
    output logic [ROW_MAX-1:0]   row,
    output logic [COL_MAX-1:0]   col,
    output logic                 dec_err
);
    localparam int OFF_W = ADDR_W - SEL_W;

    logic [SEL_W-1:0]  top_bits;
    logic [OFF_W-1:0]  offset;
    logic [SEL_W-1:0]  base_arr [NUM_CS];
    logic [SEL_W-1:0]  mask_arr [NUM_CS];
    logic [NUM_CS-1:0] en_vec;
    logic [NUM_CS-1:0] hit_vec;
    logic [NUM_CS-1:0] pick;
    logic              miss;
    map_cfg_t          cfg;
    dram_coord_t       coord_nxt;
    map_out_t          out_nxt;
    map_out_t          out_q;

    assign top_bits = req_addr[ADDR_W-1 -: SEL_W];
    assign offset   = req_addr[OFF_W-1:0];

    assign base_arr[0] = cs0_base;
    assign mask_arr[0] = cs0_mask;
    assign base_arr[1] = cs1_base;
    assign mask_arr[1] = cs1_mask;
    assign en_vec      = {cs1_present, 1'b1};

    for (genvar g = 0; g < NUM_CS; g++) begin : g_match
        dam_cs_match #(.SEL_W(SEL_W)) match_i (
            .top_bits (top_bits),
            .base     (base_arr[g]),
            .mask     (mask_arr[g]),
            .enable   (en_vec[g]),
            .hit      (hit_vec[g])
        );
    end

    dam_cs_pick #(.N(NUM_CS)) pick_i (
        .hits (hit_vec),
        .sel  (pick),
        .miss (miss)
    );

    always_comb begin
        cfg.row_sel = row_sel;
        cfg.col_sel = col_sel;
        cfg.bank8   = bank8;
        cfg.wide32  = wide32;
        cfg.mode    = interleave ? MAP_INTERLEAVED : MAP_LINEAR;
    end

    dam_field_split #(.OFF_W(OFF_W)) split_i (
        .offset (offset),
        .cfg    (cfg),
        .coord  (coord_nxt)
    );

    always_comb begin
        out_nxt = '0;
        if (req_valid) begin
            out_nxt.valid = 1'b1;
            out_nxt.err   = miss;
            if (!miss) begin
                out_nxt.cs    = pick;
                out_nxt.coord = coord_nxt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_nxt;
    end

    assign map_valid = out_q.valid;
    assign cs_sel    = out_q.cs;
    assign bank      = out_q.coord.bank;
    assign row       = out_q.coord.row;
    assign col       = out_q.coord.col;
    assign dec_err   = out_q.err;
endmodule

// File: rtl/dam_checker.sv
module dam_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        cs1_present,
    input logic [1:0]  row_sel,
    input logic [2:0]  col_sel,
    input logic        bank8,
    input logic        map_valid,
    input logic [1:0]  cs_sel,
    input logic [2:0]  bank,
    input logic [14:0] row,
    input logic [10:0] col,
    input logic        dec_err
);
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> map_valid);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!map_valid && cs_sel == 2'b00 && !dec_err
                        && bank == '0 && row == '0 && col == '0));

    p_cs_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cs_sel));

    p_no_cs1_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !cs1_present) |=> !cs_sel[1]);

    p_err_excl_r6: assert property (@(posedge clk) disable iff (rst)
        dec_err |-> (map_valid && cs_sel == 2'b00
                     && bank == '0 && row == '0 && col == '0));

    p_valid_outcome_r6: assert property (@(posedge clk) disable iff (rst)
        map_valid |-> ($countones(cs_sel) == 1) != dec_err);

    p_col_width_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && col_sel == 3'd0) |=> col[10:7] == 4'd0);

    p_row_bank_width_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && row_sel == 2'd0 && !bank8) |=> (row[14:12] == 3'd0 && !bank[2]));
endmodule

bind dam_addr_map dam_checker chk_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .cs1_present (cs1_present),
    .row_sel     (row_sel),
    .col_sel     (col_sel),
    .bank8       (bank8),
    .map_valid   (map_valid),
    .cs_sel      (cs_sel),
    .bank        (bank),
    .row         (row),
    .col         (col),
    .dec_err     (dec_err)
);

// File: tb/dam_addr_map_tb_top.sv
`timescale 1ns/1ps
module dam_addr_map_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [31:0] req_addr;
    logic [7:0]  cs0_base, cs0_mask, cs1_base, cs1_mask;
    logic        cs1_present;
    logic [1:0]  row_sel;
    logic [2:0]  col_sel;
    logic        bank8, wide32, interleave;
    logic        map_valid;
    logic [1:0]  cs_sel;
    logic [2:0]  bank;
    logic [14:0] row;
    logic [10:0] col;
    logic        dec_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dam_addr_map dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .cs0_base(cs0_base), .cs0_mask(cs0_mask), .cs1_base(cs1_base), .cs1_mask(cs1_mask),
        .cs1_present(cs1_present), .row_sel(row_sel), .col_sel(col_sel), .bank8(bank8),
        .wide32(wide32), .interleave(interleave), .map_valid(map_valid), .cs_sel(cs_sel),
        .bank(bank), .row(row), .col(col), .dec_err(dec_err)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [7:0]  c1b;
        logic [7:0]  c1m;
        logic        pres;
        logic [1:0]  rs;
        logic [2:0]  cs;
        logic        b8;
        logic        w32;
        logic        il;
        logic [1:0]  e_cs;
        logic [2:0]  e_bank;
        logic [14:0] e_row;
        logic [10:0] e_col;
        logic        e_err;
    } vec_t;

    localparam int NV = 17;
    // chip 0 is fixed at base 0x20 mask 0xF0 for every vector
    localparam vec_t VEC [NV] = '{
        '{32'h2000_0000, 8'h40, 8'hE0, 1'b1, 2'd1, 3'd3, 1'b1, 1'b1, 1'b0, 2'b01, 3'd0, 15'h0000, 11'h000, 1'b0}, // R3 R10
        '{32'h2012_3458, 8'h40, 8'hE0, 1'b1, 2'd1, 3'd3, 1'b1, 1'b1, 1'b0, 2'b01, 3'd0, 15'h0123, 11'h116, 1'b0}, // R10
        '{32'h2FFF_FFFF, 8'h40, 8'hE0, 1'b1, 2'd1, 3'd3, 1'b1, 1'b1, 1'b0, 2'b01, 3'd0, 15'h0FFF, 11'h3FF, 1'b0}, // R8 R9
        '{32'h2012_3458, 8'h40, 8'hE0, 1'b1, 2'd1, 3'd3, 1'b1, 1'b1, 1'b1, 2'b01, 3'd3, 15'h0024, 11'h116, 1'b0}, // R11
        '{32'h2055_AA01, 8'h40, 8'hE0, 1'b1, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 2'b01, 3'd1, 15'h05AA, 11'h000, 1'b0}, // R10 R7
        '{32'h2055_AA01, 8'h40, 8'hE0, 1'b1, 2'd0, 3'd0, 1'b0, 1'b0, 1'b1, 2'b01, 3'd2, 15'h056A, 11'h000, 1'b0}, // R11
        '{32'h5123_4567, 8'h40, 8'hE0, 1'b1, 2'd2, 3'd2, 1'b0, 1'b1, 1'b0, 2'b10, 3'd0, 15'h0468, 11'h159, 1'b0}, // R3 chip1
        '{32'h3000_0000, 8'h40, 8'hE0, 1'b1, 2'd1, 3'd3, 1'b1, 1'b1, 1'b0, 2'b00, 3'd0, 15'h0000, 11'h000, 1'b1}, // R6
        '{32'h4000_0000, 8'h40, 8'hE0, 1'b0, 2'd1, 3'd3, 1'b1, 1'b1, 1'b0, 2'b00, 3'd0, 15'h0000, 11'h000, 1'b1}, // R4
        '{32'h4000_0000, 8'h40, 8'hE0, 1'b1, 2'd1, 3'd3, 1'b1, 1'b1, 1'b0, 2'b10, 3'd0, 15'h0000, 11'h000, 1'b0}, // R4
        '{32'h2000_0000, 8'h20, 8'h00, 1'b1, 2'd1, 3'd3, 1'b1, 1'b1, 1'b0, 2'b01, 3'd0, 15'h0000, 11'h000, 1'b0}, // R5
        '{32'h9000_0000, 8'h20, 8'h00, 1'b1, 2'd1, 3'd3, 1'b1, 1'b1, 1'b0, 2'b10, 3'd0, 15'h0000, 11'h000, 1'b0}, // R3 mask
        '{32'h2000_3FFC, 8'h40, 8'hE0, 1'b1, 2'd0, 3'd7, 1'b0, 1'b1, 1'b0, 2'b01, 3'd0, 15'h0001, 11'h7FF, 1'b0}, // R8 clamp
        '{32'h20E0_0000, 8'h40, 8'hE0, 1'b1, 2'd0, 3'd0, 1'b1, 1'b0, 1'b0, 2'b01, 3'd6, 15'h0000, 11'h000, 1'b0}, // R9 8 banks
        '{32'h20E0_0000, 8'h40, 8'hE0, 1'b1, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 2'b01, 3'd2, 15'h0000, 11'h000, 1'b0}, // R9 4 banks
        '{32'h2000_0006, 8'h40, 8'hE0, 1'b1, 2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 2'b01, 3'd0, 15'h0000, 11'h003, 1'b0}, // R7 16-bit
        '{32'h2000_0006, 8'h40, 8'hE0, 1'b1, 2'd0, 3'd0, 1'b0, 1'b1, 1'b0, 2'b01, 3'd0, 15'h0000, 11'h001, 1'b0}  // R7 32-bit
    };

    task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0h expected=%0h", what, got, exp);
        end
    endtask

    task automatic check_all(input string tag, input logic v, input logic [1:0] c,
                             input logic [2:0] b, input logic [14:0] r,
                             input logic [10:0] k, input logic e);
        check({tag, " map_valid"}, 32'(map_valid), 32'(v));
        check({tag, " cs_sel"},    32'(cs_sel),    32'(c));
        check({tag, " bank"},      32'(bank),      32'(b));
        check({tag, " row"},       32'(row),       32'(r));
        check({tag, " col"},       32'(col),       32'(k));
        check({tag, " dec_err"},   32'(dec_err),   32'(e));
    endtask

    task automatic apply(input vec_t v);
        req_addr    = v.addr;
        cs1_base    = v.c1b;
        cs1_mask    = v.c1m;
        cs1_present = v.pres;
        row_sel     = v.rs;
        col_sel     = v.cs;
        bank8       = v.b8;
        wide32      = v.w32;
        interleave  = v.il;
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b1; req_addr = 32'h2012_3458;
        cs0_base = 8'h20; cs0_mask = 8'hF0; cs1_base = 8'h40; cs1_mask = 8'hE0;
        cs1_present = 1'b1; row_sel = 2'd1; col_sel = 3'd3;
        bank8 = 1'b1; wide32 = 1'b1; interleave = 1'b0;
        repeat (3) @(negedge clk);
        check_all("R1 reset", 1'b0, 2'b00, 3'd0, 15'd0, 11'd0, 1'b0);

        @(negedge clk) rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            req_valid = 1'b1;
            @(negedge clk);
            check_all($sformatf("vec%0d R2 R3 R5 R6 R7 R8 R9 R10 R11", i), 1'b1,
                      VEC[i].e_cs, VEC[i].e_bank, VEC[i].e_row, VEC[i].e_col, VEC[i].e_err);
        end

        // R2: idle request, address would otherwise map to chip 0
        apply(VEC[1]);
        req_valid = 1'b0;
        @(negedge clk);
        check_all("R2 idle", 1'b0, 2'b00, 3'd0, 15'd0, 11'd0, 1'b0);

        // R2: idle with a non-matching address still shows no error
        apply(VEC[7]);
        @(negedge clk);
        check_all("R2 idle miss", 1'b0, 2'b00, 3'd0, 15'd0, 11'd0, 1'b0);

        // R1: reset mid-stream with a valid request pending
        apply(VEC[3]);
        req_valid = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        check_all("R1 mid reset", 1'b0, 2'b00, 3'd0, 15'd0, 11'd0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check_all("R11 after reset", 1'b1, 2'b01, 3'd3, 15'h0024, 11'h116, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R2 got=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule